// File: doc/BRIEF.md
# Nibble Accumulator Controller

This block is a tiny 4-bit processor built around a single accumulator register. It fetches 16-bit instruction words from an external program store through a 12-bit address and a combinational read port, and it executes one instruction per clock. It has no adder. Its only datapath operators are a +1 incrementer on the accumulator and an equality comparator between the accumulator and a data nibble.

Data lives in a 16-nibble scratch RAM inside the block. The highest RAM location is not storage. A read from it returns the external input port, and a write to it updates the latch that drives the output port. Control flow uses two mechanisms: an unconditional jump to an absolute 12-bit target, and a compare that skips the following instruction when the accumulator matches a RAM nibble.

The opcode sits in instruction bits [15:13]. Jump targets come from bits [11:0]. RAM addresses and immediates come from bits [3:0].

Top module: `nib_core`

## Requirements
- R1: While `rst_n` is low, and on the first cycle after it rises, `imem_addr` is 0 and `out_port` is 0. The accumulator is also cleared, so a store to address 15 issued right after reset drives 0 onto `out_port`.
- R2: Opcode 3'b001 loads bits [3:0] of the instruction into the accumulator, and the program counter advances by one.
- R3: Opcode 3'b000 loads the RAM nibble addressed by bits [3:0] into the accumulator. When that address is 15, the value loaded is the current `in_port`.
- R4: Opcode 3'b101 writes the accumulator to the RAM nibble addressed by bits [3:0]. A store to address 15 updates `out_port` on the next clock edge. A store to any other address leaves `out_port` unchanged, and a later load reads the stored value back.
- R5: Opcode 3'b010 adds one to the accumulator, wrapping from 15 to 0.
- R6: Opcode 3'b011 loads instruction bits [11:0] into the program counter.
- R7: Opcode 3'b100 compares the accumulator with the addressed nibble (the input port when the address is 15). The program counter advances by two when they are equal and by one when they differ.
- R8: Program counter arithmetic wraps modulo 4096: a step from 12'hFFF, and a skip from 12'hFFE, both land on 12'h000.
- R9: Opcodes 3'b110 and 3'b111 only advance the program counter. The accumulator, the RAM and `out_port` keep their values.
- R10: `out_port` holds its value between stores to address 15, whatever `in_port` does.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; all state updates on the rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| imem_addr | output | 12 | Program counter, driven to the program store |
| imem_data | input | 16 | Instruction word at `imem_addr`, same cycle |
| in_port | input | 4 | External input, read at RAM address 15 |
| out_port | output | 4 | Output latch, written at RAM address 15 |

## Verification
The bench builds the block with its default parameters: 4-bit data, a 12-bit program counter, 16-bit instructions and 16 RAM nibbles. These values put the input/output location at address 15. They also let a single jump reach the last two program addresses, so both wrap paths of the program counter (the plain step and the skip) are exercised within a few cycles. The bench acts as the program store itself and feeds one instruction word per cycle. The accumulator is observed through stores to address 15, and the program counter is observed on `imem_addr`.

// File: rtl/nib_pkg.sv
package nib_pkg;

    localparam int OPC_W = 3;

    typedef enum logic [OPC_W-1:0] {
        OP_LDM  = 3'd0,
        OP_LDI  = 3'd1,
        OP_INC  = 3'd2,
        OP_JMP  = 3'd3,
        OP_SKE  = 3'd4,
        OP_STM  = 3'd5,
        OP_RSV6 = 3'd6,
        OP_RSV7 = 3'd7
    } op_t;

endpackage

// File: rtl/nib_decode.sv
module nib_decode
    import nib_pkg::*;
#(
    parameter int INSTR_W = 16,
    parameter int PC_W    = 12,
    parameter int DATA_W  = 4,
    parameter int AW      = 4
) (
    input  logic [INSTR_W-1:0] instr,
    output op_t                opcode,
    output logic [AW-1:0]      addr,
    output logic [DATA_W-1:0]  imm,
    output logic [PC_W-1:0]    target
);

    localparam int PAD_W = INSTR_W - OPC_W - PC_W;

    always_comb begin
        opcode = op_t'(instr[INSTR_W-1 -: OPC_W]);
        addr   = instr[AW-1:0];
        imm    = instr[DATA_W-1:0];
        target = instr[PC_W-1:0];
    end

    generate
        if (PAD_W > 0) begin : g_pad
            logic [PAD_W-1:0] unused_pad;
            assign unused_pad = instr[PC_W +: PAD_W];
        end
    endgenerate

endmodule

// File: rtl/nib_ram.sv
module nib_ram #(
    parameter int DATA_W = 4,
    parameter int DEPTH  = 16,
    localparam int AW    = $clog2(DEPTH)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [AW-1:0]     addr,
    input  logic              we,
    input  logic [DATA_W-1:0] wr_data,
    output logic [DATA_W-1:0] rd_data,
    input  logic [DATA_W-1:0] in_port,
    output logic [DATA_W-1:0] out_port
);

    localparam logic [AW-1:0] IO_ADDR = AW'(DEPTH - 1);
    localparam int            CELLS   = DEPTH - 1;

    logic [DATA_W-1:0] cell_d [CELLS];
    logic [DATA_W-1:0] cell_q [CELLS];
    logic [DATA_W-1:0] out_d;
    logic [DATA_W-1:0] out_q;
    logic              io_sel;

    always_comb begin
        io_sel = (addr == IO_ADDR);
        out_d  = out_q;
        if (we && io_sel) begin
            out_d = wr_data;
        end
        rd_data = in_port;
        for (int i = 0; i < CELLS; i++) begin
            cell_d[i] = cell_q[i];
            if (we && addr == AW'(i)) begin
                cell_d[i] = wr_data;
            end
            if (addr == AW'(i)) begin
                rd_data = cell_q[i];
            end
        end
    end

    generate
        for (genvar g = 0; g < CELLS; g++) begin : g_cell
            always_ff @(posedge clk) begin
                if (!rst_n) begin
                    cell_q[g] <= '0;
                end else begin
                    cell_q[g] <= cell_d[g];
                end
            end
        end
    endgenerate

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_q <= '0;
        end else begin
            out_q <= out_d;
        end
    end

    assign out_port = out_q;

    // R4: a store to the top location shows up on the output latch
    p_out_load_r4: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) && $past(we) && $past(addr) == IO_ADDR
        |-> out_port == $past(wr_data));

    // R10: without a store to the top location, the latch holds
    p_out_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) && !($past(we) && $past(addr) == IO_ADDR)
        |-> $stable(out_port));

endmodule

// File: rtl/nib_core.sv
module nib_core
    import nib_pkg::*;
#(
    parameter int DATA_W    = 4,
    parameter int PC_W      = 12,
    parameter int INSTR_W   = 16,
    parameter int RAM_DEPTH = 16
) (
    input  logic               clk,
    input  logic               rst_n,
    output logic [PC_W-1:0]    imem_addr,
    input  logic [INSTR_W-1:0] imem_data,
    input  logic [DATA_W-1:0]  in_port,
    output logic [DATA_W-1:0]  out_port
);

    localparam int              AW     = $clog2(RAM_DEPTH);
    localparam logic [PC_W-1:0] PC_ONE = PC_W'(1);
    localparam logic [PC_W-1:0] PC_TWO = PC_W'(2);

    typedef struct packed {
        logic [PC_W-1:0]   pc;
        logic [DATA_W-1:0] acc;
    } core_t;

    core_t             st_d;
    core_t             st_q;
    op_t               opcode;
    logic [AW-1:0]     addr;
    logic [DATA_W-1:0] imm;
    logic [PC_W-1:0]   target;
    logic [DATA_W-1:0] rd_data;
    logic              ram_we;
    logic              match;

    nib_decode #(
        .INSTR_W (INSTR_W),
        .PC_W    (PC_W),
        .DATA_W  (DATA_W),
        .AW      (AW)
    ) u_decode (
        .instr  (imem_data),
        .opcode (opcode),
        .addr   (addr),
        .imm    (imm),
        .target (target)
    );

    nib_ram #(
        .DATA_W (DATA_W),
        .DEPTH  (RAM_DEPTH)
    ) u_ram (
        .clk      (clk),
        .rst_n    (rst_n),
        .addr     (addr),
        .we       (ram_we),
        .wr_data  (st_q.acc),
        .rd_data  (rd_data),
        .in_port  (in_port),
        .out_port (out_port)
    );

    always_comb begin
        st_d   = st_q;
        ram_we = 1'b0;
        match  = (st_q.acc == rd_data);
        st_d.pc = st_q.pc + PC_ONE;
        case (opcode)
            OP_LDM: st_d.acc = rd_data;
            OP_LDI: st_d.acc = imm;
            OP_INC: st_d.acc = st_q.acc + DATA_W'(1);
            OP_JMP: st_d.pc  = target;
            OP_SKE: begin
                if (match) begin
                    st_d.pc = st_q.pc + PC_TWO;
                end
            end
            OP_STM: ram_we = 1'b1;
            default: ;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign imem_addr = st_q.pc;

    // R6: a jump lands on the target field
    p_jump_r6: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) && $past(opcode) == OP_JMP
        |-> imem_addr == $past(target));

    // R7: a matching compare moves the counter two places
    p_skip_r7: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) && $past(opcode) == OP_SKE && $past(st_q.acc) == $past(rd_data)
        |-> imem_addr == $past(imem_addr) + PC_TWO);

    // R5: increment steps the accumulator by one, modulo the data width
    p_inc_wrap_r5: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) && $past(opcode) == OP_INC
        |-> st_q.acc == DATA_W'($past(st_q.acc) + DATA_W'(1)));

    // R2: immediate load takes the low field
    p_ldi_r2: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) && $past(opcode) == OP_LDI
        |-> st_q.acc == $past(imm) && imem_addr == $past(imem_addr) + PC_ONE);

    // R9: reserved opcodes leave the accumulator alone
    p_rsv_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) && ($past(opcode) == OP_RSV6 || $past(opcode) == OP_RSV7)
        |-> $stable(st_q.acc) && imem_addr == $past(imem_addr) + PC_ONE);

endmodule

// File: tb/nib_core_tb.sv
module nib_core_tb;

    localparam int CLK_PERIOD = 10;
    localparam int NVEC       = 23;

    typedef struct packed {
        logic [15:0] instr;
        logic [3:0]  inp;
        logic [11:0] pc;
        logic [3:0]  out;
        logic [3:0]  req;
    } vec_t;

    // opcodes in bits [15:13]: LDM 0x0, LDI 0x2, INC 0x4, JMP 0x6,
    // SKE 0x8, STM 0xA, reserved 0xC / 0xE
    localparam vec_t VEC [0:NVEC-1] = '{
        '{16'h2009, 4'h0, 12'h001, 4'h0, 4'd2},  // R2  acc=9
        '{16'hA00F, 4'h0, 12'h002, 4'h9, 4'd4},  // R4  out=9
        '{16'hA003, 4'h0, 12'h003, 4'h9, 4'd4},  // R4  ram3=9, out kept
        '{16'h200F, 4'h0, 12'h004, 4'h9, 4'd2},  // R2  acc=F
        '{16'h4000, 4'h0, 12'h005, 4'h9, 4'd5},  // R5  acc wraps to 0
        '{16'hA00F, 4'h0, 12'h006, 4'h0, 4'd5},  // R5  out shows 0
        '{16'h0003, 4'h0, 12'h007, 4'h0, 4'd4},  // R4  read back ram3
        '{16'hA00F, 4'h0, 12'h008, 4'h9, 4'd3},  // R3  out=9
        '{16'h000F, 4'h6, 12'h009, 4'h9, 4'd3},  // R3  acc=in=6
        '{16'hA00F, 4'h0, 12'h00A, 4'h6, 4'd3},  // R3  out=6
        '{16'h8003, 4'h0, 12'h00B, 4'h6, 4'd7},  // R7  6!=9, step 1
        '{16'h2009, 4'h0, 12'h00C, 4'h6, 4'd2},  // R2  acc=9
        '{16'h8003, 4'h0, 12'h00E, 4'h6, 4'd7},  // R7  9==9, step 2
        '{16'h6FFE, 4'h0, 12'hFFE, 4'h6, 4'd6},  // R6  jump
        '{16'h800F, 4'h9, 12'h000, 4'h6, 4'd8},  // R8  skip on port wraps
        '{16'hE005, 4'h0, 12'h001, 4'h6, 4'd9},  // R9  reserved 7
        '{16'h4000, 4'h0, 12'h002, 4'h6, 4'd5},  // R5  acc=A
        '{16'hA00F, 4'h0, 12'h003, 4'hA, 4'd9},  // R9  acc survived
        '{16'h6FFF, 4'h0, 12'hFFF, 4'hA, 4'd6},  // R6  jump to top
        '{16'h2001, 4'h0, 12'h000, 4'hA, 4'd8},  // R8  step wraps
        '{16'hA00F, 4'h3, 12'h001, 4'h1, 4'd4},  // R4  out=1
        '{16'h2004, 4'h7, 12'h002, 4'h1, 4'd10}, // R10 port moves, out held
        '{16'hC000, 4'hF, 12'h003, 4'h1, 4'd9}   // R9  reserved 6
    };

    logic        clk;
    logic        rst_n;
    logic [11:0] imem_addr;
    logic [15:0] imem_data;
    logic [3:0]  in_port;
    logic [3:0]  out_port;

    int checks;
    int failures;
    bit done;

    nib_core u_dut (
        .clk       (clk),
        .rst_n     (rst_n),
        .imem_addr (imem_addr),
        .imem_data (imem_data),
        .in_port   (in_port),
        .out_port  (out_port)
    );

    initial clk = 1'b0;
    always #(CLK_PERIOD / 2) clk = ~clk;

    task automatic check(input string req, input string what,
                         input logic [15:0] act, input logic [15:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    task automatic summary();
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    endtask

    initial begin
        #(CLK_PERIOD * 20000);
        if (!done) begin
            checks++;
            failures++;
            $display("FAIL watchdog: actual=timeout expected=completion");
            summary();
        end
    end

    initial begin
        checks    = 0;
        failures  = 0;
        done      = 1'b0;
        rst_n     = 1'b0;
        imem_data = 16'hC000;
        in_port   = 4'h0;
        @(negedge clk);
        @(negedge clk);
        // R1: state held at zero during reset
        check("R1", "pc in reset", {4'h0, imem_addr}, 16'h0000);
        check("R1", "out in reset", {12'h0, out_port}, 16'h0000);

        rst_n = 1'b1;
        for (int i = 0; i < NVEC; i++) begin
            imem_data = VEC[i].instr;
            in_port   = VEC[i].inp;
            @(negedge clk);
            check($sformatf("R%0d", VEC[i].req), $sformatf("vec %0d pc", i),
                  {4'h0, imem_addr}, {4'h0, VEC[i].pc});
            check($sformatf("R%0d", VEC[i].req), $sformatf("vec %0d out", i),
                  {12'h0, out_port}, {12'h0, VEC[i].out});
        end

        // R1: reset in mid-run clears pc, latch and accumulator (acc is 4)
        rst_n     = 1'b0;
        imem_data = 16'hC000;
        @(negedge clk);
        check("R1", "pc after mid reset", {4'h0, imem_addr}, 16'h0000);
        check("R1", "out after mid reset", {12'h0, out_port}, 16'h0000);
        rst_n     = 1'b1;
        imem_data = 16'hA00F;
        @(negedge clk);
        check("R1", "acc cleared seen on out", {12'h0, out_port}, 16'h0000);
        check("R1", "pc first step", {4'h0, imem_addr}, 16'h0001);

        // R10: port toggles across reserved cycles, latch steady
        imem_data = 16'hE000;
        for (int k = 0; k < 4; k++) begin
            in_port = 4'(k * 5 + 3);
            @(negedge clk);
        end
        check("R10", "out held with port toggling", {12'h0, out_port}, 16'h0000);

        // R3 and R7: compare against the port at address 15 after a load
        imem_data = 16'h000F;
        in_port   = 4'hC;
        @(negedge clk);
        imem_data = 16'h800F;
        in_port   = 4'hD;
        @(negedge clk);
        check("R7", "port mismatch steps one", {4'h0, imem_addr}, 16'h0007);
        imem_data = 16'hA00F;
        @(negedge clk);
        check("R3", "acc from port", {12'h0, out_port}, 16'h000C);

        done = 1'b1;
        summary();
    end

endmodule